// File: doc/BRIEF.md
# Frequency Synthesiser Divider Chain with Lock Detect

This block is the digital heart of a phase-locked frequency synthesiser. It runs from a single reference clock (nominally 4 MHz). A fixed reference divider turns that clock into a comparison tick. A programmable divider counts pulses of the already-prescaled RF signal down by a loaded divisor and produces a feedback tick. A two-flip-flop phase/frequency detector compares the two ticks and issues up and down pump requests. A lock detector watches how wide those requests are and reports when the loop has settled.

The prescaled RF signal arrives as a one-cycle enable pulse that is synchronous to the reference clock. A mode input selects the standard. When the mode input is high, the comparison tick comes every 512 clocks (7.8125 kHz at 4 MHz) and the divisor uses 14 bits. When the mode input is low, the tick comes every 640 clocks (6.25 kHz) and the divisor uses all 15 bits. The lock output models an open-drain pin: it is driven low when locked and released high when unlocked. Both divided signals are brought out so that they can be observed.

Top module: `pll_divchain`

## Requirements
- R1: With `mode_hi` = 1, `ref_div` pulses high for one clock every 512 clocks.
- R2: With `mode_hi` = 0, `ref_div` pulses high for one clock every 640 clocks.
- R3: `fb_div` pulses high for one clock after every N sampled `rf_pulse` highs. With `mode_hi` = 0, N is the full 15-bit `divisor`. With `mode_hi` = 1, bit 14 is ignored and N is `divisor[13:0]`.
- R4: A `ref_div` tick that arrives before its matching `fb_div` tick raises `pump_up` until the `fb_div` tick. The opposite order raises `pump_dn`. `pump_up` and `pump_dn` are never high in the same cycle.
- R5: While `pump_dis` = 1, `pump_up` and `pump_dn` are both 0.
- R6: A ratio (after the R3 masking) of 0 or 1 divides by 2.
- R7: A change of `divisor` takes effect only when the current feedback interval ends. The interval in progress keeps its old length.
- R8: `lock_n` is 1 after reset. It goes to 0 after 8 consecutive comparison ticks in which no up or down request lasted longer than LOCK_TOL (default 4) clocks.
- R9: A pump request that stays high for more than LOCK_TOL clocks sets `lock_n` to 1 at once. A run visible for LOCK_TOL+2 sampled cycles never coexists with `lock_n` = 0.
- R10: A change of `mode_hi` restarts both dividers from their load values, clears the pump requests, and sets `lock_n` to 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_hi | input | 1 | Standard select: 1 gives ÷512 and a 14-bit ratio, 0 gives ÷640 and a 15-bit ratio |
| rf_pulse | input | 1 | One-cycle pulse per prescaled RF period |
| divisor | input | 15 | Programmable divider ratio |
| pump_dis | input | 1 | Forces both pump requests inactive |
| pump_up | output | 1 | Up request (reference leads) |
| pump_dn | output | 1 | Down request (feedback leads) |
| lock_n | output | 1 | 0 = locked, 1 = released (unlocked) |
| ref_div | output | 1 | Comparison tick for observation |
| fb_div | output | 1 | Feedback tick for observation |

## Verification
The hardest condition to reach is the instant a locked loop loses lock. The pump request width has to climb past the tolerance while the lock flag is still set. The bench first locks the loop with the feedback ratio equal to the reference ratio and RF pulses on every clock. It then raises the divisor by one, so the phase error grows by one clock per comparison. The bench watches the exact sampled cycle at which the run of a request reaches LOCK_TOL+2. The rule that a new divisor waits for the boundary is reached by writing a new ratio a few clocks into a feedback interval and timing that interval and the next one.

// File: rtl/pll_divchain_pkg.sv
// Package: shared widths and types of the synthesiser divider chain.
// Assumes one reference clock domain for every block that imports it.
package pll_divchain_pkg;
    localparam int DIV_W      = 15;   // full programmable ratio width
    localparam int DIV_W_NARROW = 14; // ratio width with the top bit bypassed
    typedef logic [DIV_W-1:0] div_word_t;
endpackage

// File: rtl/pll_ref_divider.sv
// Reference divider: issues a one-cycle tick every HI_RATIO clocks when
// mode_hi is 1, and every LO_RATIO clocks otherwise.
// Assumes restart is asserted for one cycle whenever the mode changes.
module pll_ref_divider #(
    parameter int HI_RATIO = 512,
    parameter int LO_RATIO = 640
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_hi,
    input  logic restart,
    output logic tick
);
    localparam int MAX_RATIO = (HI_RATIO > LO_RATIO) ? HI_RATIO : LO_RATIO;
    localparam int CNT_W     = $clog2(MAX_RATIO);
    localparam logic [CNT_W-1:0] HI_M1 = CNT_W'(HI_RATIO - 1);
    localparam logic [CNT_W-1:0] LO_M1 = CNT_W'(LO_RATIO - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    // Pick the reload value for the current standard.
    always_comb begin
        load_val = mode_hi ? HI_M1 : LO_M1;
    end

    // Count down to zero, emit a tick and reload.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= load_val;
            tick  <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q <= load_val;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
            tick  <= 1'b0;
        end
    end

    // The counter never leaves the range of the selected ratio.
    assert_ref_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= (mode_hi ? HI_M1 : LO_M1) || $past(mode_hi) != mode_hi);

    // Ticks are isolated single-cycle pulses.
    assert_ref_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/pll_prog_divider.sv
// Programmable divider: counts rf_pulse enables down from the effective
// ratio and emits a one-cycle tick after the last one. The ratio is taken
// from the divisor only at reload. With mode_hi set, the top bit is ignored.
// Ratios below two are raised to two.
// Assumes rf_pulse is synchronous to clk.
module pll_prog_divider
    import pll_divchain_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_hi,
    input  logic      restart,
    input  logic      rf_pulse,
    input  div_word_t divisor,
    output logic      tick
);
    div_word_t masked;
    div_word_t eff_ratio;
    div_word_t cnt_q;

    // Apply top-bit bypass and the minimum-ratio clamp.
    always_comb begin
        masked    = mode_hi ? {1'b0, divisor[DIV_W_NARROW-1:0]} : divisor;
        eff_ratio = (masked < div_word_t'(2)) ? div_word_t'(2) : masked;
    end

    // Count RF enables and reload at the terminal count only.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= eff_ratio;
            tick  <= 1'b0;
        end else if (rf_pulse) begin
            if (cnt_q == div_word_t'(1)) begin
                cnt_q <= eff_ratio;
                tick  <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
                tick  <= 1'b0;
            end
        end else begin
            tick <= 1'b0;
        end
    end

    // The counter never stalls at zero.
    assert_cnt_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0);

    // A tick is always the consequence of a consumed RF enable.
    assert_tick_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(rf_pulse));

    // Between RF enables the count holds.
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rf_pulse && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/pll_pfd.sv
// Phase/frequency detector: an up flop set by the reference tick and a down
// flop set by the feedback tick. Both clear once both would be set, so
// simultaneous ticks produce no request.
// Assumes ticks are single-cycle pulses in the clk domain.
module pll_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic ref_tick,
    input  logic fb_tick,
    output logic up_q,
    output logic dn_q
);
    logic up_nx;
    logic dn_nx;
    logic both;

    // Next-state of both flops including the mutual clear.
    always_comb begin
        up_nx = up_q | ref_tick;
        dn_nx = dn_q | fb_tick;
        both  = up_nx & dn_nx;
    end

    // Register the request flops.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= up_nx & ~both;
            dn_q <= dn_nx & ~both;
        end
    end

    // The two requests are mutually exclusive.
    assert_pfd_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_q && dn_q));

    // A lone reference tick with no pending down opens an up request.
    assert_up_on_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick && !fb_tick && !dn_q && !restart) |=> up_q);

    // A lone feedback tick with no pending up opens a down request.
    assert_dn_on_fb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_tick && !ref_tick && !up_q && !restart) |=> dn_q);
endmodule

// File: rtl/pll_lock_det.sv
// Lock detector: measures the run length of any pump request. A run longer
// than TOL clocks drops lock at once. Lock is set after RUN consecutive
// comparison ticks with no such run.
// Assumes ref_tick marks comparison cycles.
module pll_lock_det #(
    parameter int TOL = 4,
    parameter int RUN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic ref_tick,
    input  logic active,
    output logic locked
);
    localparam int W_W = $clog2(TOL + 2);
    localparam int G_W = $clog2(RUN + 1);
    localparam logic [W_W-1:0] TOL_V  = W_W'(TOL);
    localparam logic [G_W-1:0] RUN_M1 = G_W'(RUN - 1);

    logic [W_W-1:0] width_q;
    logic [G_W-1:0] good_q;
    logic           viol;

    // A request that is still high after TOL counted clocks is a violation.
    always_comb begin
        viol = active && (width_q >= TOL_V);
    end

    // Track the width of the current request run.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !active) begin
            width_q <= '0;
        end else if (!viol) begin
            width_q <= width_q + 1'b1;
        end
    end

    // Count clean comparison cycles and hold the lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || viol) begin
            good_q <= '0;
            locked <= 1'b0;
        end else if (ref_tick) begin
            if (good_q == RUN_M1) begin
                locked <= 1'b1;
            end else begin
                good_q <= good_q + 1'b1;
            end
        end
    end

    // Lock only appears on a comparison tick.
    assert_lock_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(ref_tick));

    // An over-long request clears lock on the next edge.
    assert_drop_fast_R9: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> !locked);

    // A restart always leaves the loop unlocked.
    assert_restart_unlock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !locked);
endmodule

// File: rtl/pll_divchain.sv
// Top of the synthesiser divider chain: reference divider, programmable
// divider, phase/frequency detector and lock detector. A mode change
// restarts every stage. Pump outputs are gated by pump_dis. The lock output
// is active-low to model an open-drain pin.
// Assumes all inputs are synchronous to clk.
module pll_divchain
    import pll_divchain_pkg::*;
#(
    parameter int HI_RATIO = 512,
    parameter int LO_RATIO = 640,
    parameter int LOCK_TOL = 4,
    parameter int LOCK_RUN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_hi,
    input  logic             rf_pulse,
    input  logic [DIV_W-1:0] divisor,
    input  logic             pump_dis,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             lock_n,
    output logic             ref_div,
    output logic             fb_div
);
    logic mode_q;
    logic restart;
    logic ref_tick;
    logic fb_tick;
    logic up_q;
    logic dn_q;
    logic locked;

    // Remember the mode so that a change can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= mode_hi;
        end else begin
            mode_q <= mode_hi;
        end
    end

    // A mode edge restarts the chain.
    always_comb begin
        restart = rst_n && (mode_hi != mode_q);
    end

    pll_ref_divider #(
        .HI_RATIO(HI_RATIO),
        .LO_RATIO(LO_RATIO)
    ) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_hi(mode_hi),
        .restart(restart),
        .tick   (ref_tick)
    );

    pll_prog_divider u_prog (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_hi (mode_hi),
        .restart (restart),
        .rf_pulse(rf_pulse),
        .divisor (divisor),
        .tick    (fb_tick)
    );

    pll_pfd u_pfd (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .ref_tick(ref_tick),
        .fb_tick (fb_tick),
        .up_q    (up_q),
        .dn_q    (dn_q)
    );

    pll_lock_det #(
        .TOL(LOCK_TOL),
        .RUN(LOCK_RUN)
    ) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .ref_tick(ref_tick),
        .active  (up_q | dn_q),
        .locked  (locked)
    );

    // Drive the outputs: gated pump requests, inverted lock, observation ticks.
    always_comb begin
        pump_up = up_q & ~pump_dis;
        pump_dn = dn_q & ~pump_dis;
        lock_n  = ~locked;
        ref_div = ref_tick;
        fb_div  = fb_tick;
    end

    // Disabled pump requests stay quiet.
    assert_pump_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pump_dis |-> (!pump_up && !pump_dn));

    // The observed ticks follow a mode change only after a full restart.
    assert_mode_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!ref_div && !fb_div && lock_n));
endmodule

// File: tb/sim_pll_divchain.sv
module sim_pll_divchain;
    localparam int TOL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_hi = 1'b1;
    logic        rf_pulse = 1'b0;
    logic [14:0] divisor = 15'd512;
    logic        pump_dis = 1'b0;
    logic        pump_up, pump_dn, lock_n, ref_div, fb_div;

    int checks = 0, errors = 0;
    int rf_cnt = 0, fb_int = 0, fb_cnt = 0;
    int ref_cyc = 0, ref_int = 0, ref_cnt = 0;
    int run = 0, cycles = 0;
    bit up_seen = 0, dn_seen = 0, both_seen = 0, rf_rand = 0, timed_out = 0;
    int r9_hits = 0, r9_bad = 0;

    always #4 clk = ~clk;

    pll_divchain u0 (
        .clk(clk), .rst_n(rst_n), .mode_hi(mode_hi), .rf_pulse(rf_pulse),
        .divisor(divisor), .pump_dis(pump_dis), .pump_up(pump_up),
        .pump_dn(pump_dn), .lock_n(lock_n), .ref_div(ref_div), .fb_div(fb_div)
    );

    function automatic int eff_ratio(bit m, logic [14:0] d);
        int v;
        v = m ? int'(d[13:0]) : int'(d);
        return (v < 2) ? 2 : v;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cycles++;
        if (cycles > 190000) timed_out = 1;
        if (rf_pulse) rf_cnt++;
        if (fb_div) begin fb_int = rf_cnt; rf_cnt = 0; fb_cnt++; end
        ref_cyc++;
        if (ref_div) begin ref_int = ref_cyc; ref_cyc = 0; ref_cnt++; end
        run = (pump_up || pump_dn) ? run + 1 : 0;
        if (pump_up && pump_dn) both_seen = 1;
        if (pump_up) up_seen = 1;
        if (pump_dn) dn_seen = 1;
        if (run == TOL + 2) begin
            r9_hits++;
            if (!lock_n) r9_bad++;
        end
        rf_pulse = rf_rand ? 1'($urandom % 2) : 1'b1;
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n && !timed_out; i++) step();
    endtask

    task automatic wait_fb();
        int t;
        t = fb_cnt + 1;
        while (fb_cnt < t && !timed_out) step();
    endtask

    task automatic wait_ref(int n);
        int t;
        t = ref_cnt + n;
        while (ref_cnt < t && !timed_out) step();
    endtask

    initial begin
        #(8 * 195000);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R8: reset state
        check(lock_n == 1'b1, "R8 reset lock_n", lock_n, 1);
        check(!pump_up && !pump_dn, "R4 reset pumps idle", pump_up | pump_dn, 0);

        // R1 and R8: mode high, matched ratio, lock acquired
        wait_ref(2);
        check(ref_int == 512, "R1 ref period mode high", ref_int, 512);
        wait_fb(); wait_fb();
        check(fb_int == 512, "R3 fb ratio 512", fb_int, 512);
        wait_ref(10);
        check(lock_n == 1'b0, "R8 lock after clean cycles", lock_n, 0);

        // R9: ratio off by one, lag grows until lock drops
        r9_hits = 0; r9_bad = 0;
        divisor = 15'd513;
        wait_ref(14);
        check(r9_hits > 0 && r9_bad == 0, "R9 drop on long request", r9_bad, 0);
        check(lock_n == 1'b1, "R9 unlocked after drift", lock_n, 1);

        // R5: pump disable with an up-heavy error
        divisor = 15'd530;
        pump_dis = 1'b1;
        up_seen = 0; dn_seen = 0;
        steps(3000);
        check(!up_seen && !dn_seen, "R5 pumps gated", up_seen | dn_seen, 0);
        pump_dis = 1'b0;

        // R4: slow feedback gives up requests, fast gives down requests
        up_seen = 0; dn_seen = 0; both_seen = 0;
        steps(3000);
        check(up_seen, "R4 up on slow feedback", up_seen, 1);
        divisor = 15'd480;
        wait_fb(); wait_fb(); wait_fb();
        dn_seen = 0;
        steps(3000);
        check(dn_seen, "R4 down on fast feedback", dn_seen, 1);
        check(!both_seen, "R4 exclusive requests", both_seen, 0);

        // R10 and R2: change to mode low, then relock at 640
        divisor = 15'd640;
        mode_hi = 1'b0;
        step();
        check(lock_n == 1'b1, "R10 lock cleared on mode change", lock_n, 1);
        wait_ref(2);
        check(ref_int == 640, "R2 ref period mode low", ref_int, 640);
        wait_ref(10);
        check(lock_n == 1'b0, "R8 lock in mode low", lock_n, 0);
        mode_hi = 1'b1;
        divisor = 15'd512;
        step();
        check(lock_n == 1'b1, "R10 lock cleared on return", lock_n, 1);
        wait_ref(2);
        check(ref_int == 512, "R1 ref period after return", ref_int, 512);

        // R6: minimum ratio clamp
        divisor = 15'd0; wait_fb(); wait_fb();
        check(fb_int == 2, "R6 ratio zero", fb_int, 2);
        divisor = 15'd1; wait_fb(); wait_fb();
        check(fb_int == 2, "R6 ratio one", fb_int, 2);
        divisor = 15'h4001; wait_fb(); wait_fb();
        check(fb_int == 2, "R6 masked ratio one", fb_int, 2);

        // R7: change mid-interval applies at the boundary
        divisor = 15'd20; wait_fb(); wait_fb();
        steps(5);
        divisor = 15'd33;
        wait_fb();
        check(fb_int == 20, "R7 interval in progress keeps old ratio", fb_int, 20);
        wait_fb();
        check(fb_int == 33, "R7 next interval uses new ratio", fb_int, 33);

        // R3: top bit bypass in mode high, used in mode low
        divisor = 15'h4025; wait_fb(); wait_fb();
        check(fb_int == 37, "R3 top bit ignored mode high", fb_int, 37);
        mode_hi = 1'b0; wait_fb(); wait_fb();
        check(fb_int == 16421, "R3 full width mode low", fb_int, 16421);

        // R3 random: mixed modes, ratios and RF density
        rf_rand = 1;
        for (int k = 0; k < 40 && !timed_out; k++) begin
            bit m;
            logic [14:0] d;
            m = 1'($urandom % 2);
            d = 15'($urandom % 60);
            if (m && ($urandom % 2) == 1) d[14] = 1'b1;
            mode_hi = m;
            divisor = d;
            wait_fb(); wait_fb();
            check(fb_int == eff_ratio(m, d), "R3 random ratio", fb_int, eff_ratio(m, d));
        end

        if (timed_out) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule